// File: doc/BRIEF.md
# PCM Sound Generator Host Access Port

This block is the processor-facing side of an eight-voice PCM sound generator. The host writes single bytes to it. A byte can land in one of three places: the global control word, the voice-disable mask, or the seven parameter registers of whichever voice is currently selected. The byte can also go to the wave memory that the voices play from. The block also serves host reads of each voice's playback position and of wave memory. The playback engine stays outside the block. It reads wave memory through a second read port, which has priority over the host. It also provides the schedule slot number, which decides when a held write may reach memory.

A write into the wave-memory window does not reach RAM at once. The block keeps it as a single pending byte, with the bank that was current when the byte arrived. The byte is committed in a schedule slot that permits it. Three slots out of every twelve always permit a commit. Most of the other slots permit one only while the generator is silent. The refresh slot never does. While the generator is sounding, the host cannot read wave memory and gets 0xFF.

The address inside a bank is the low OFS_W bits of the host address. The bank number, BANK_W bits, sits above it, so RAM holds 2^(BANK_W+OFS_W) bytes. The full-size part uses OFS_W=12, which gives 4 KiB banks. The default build uses 256-byte banks.

Top module: `pcm_host_port`

## Requirements
- R1: A host write to address 0..6 stores the byte in that parameter register of the selected voice, and no other voice changes. Parameter index 0..6 is, in order: level, pan, step low byte, step high byte, loop low byte, loop high byte, start. Register r of voice c appears on chanParams[(c*7+r)*8 +: 8] one cycle after the write.
- R2: A write to address 7 always loads bit 7 into `sounding`. If bit 6 is set, bits 2:0 become the selected voice and the bank is kept. If bit 6 is clear, the low BANK_W bits become the wave bank and the selected voice is kept.
- R3: A write to address 7 with bit 7 clear raises `accClear` for exactly the following cycle. Any other write leaves it low.
- R4: A write to address 8 loads `disableMask`, where bit i set means voice i is silenced. In the following cycle, `restartStrobe` pulses exactly those bits that went from 0 to 1.
- R5: A write at address 0x1000 or above holds one pending byte for RAM location {bank at write time, address[OFS_W-1:0]}. A newer window write replaces the held byte and its target before the commit.
- R6: A held byte is committed in slots 3, 7 and 11 in every state. It is also committed in slots 0, 1, 2, 4, 5, 6, 8 and 9 when `sounding` is 0. It is never committed in slot 10 or in slots 12..15.
- R7: A host read of 0x10..0x1F picks voice (address>>1)&7. From that voice's 16-bit pointer field, which holds pointer bits 26:11, an odd address returns bits 15:8 and an even address returns bits 7:0. The data appears on hostRdData in the cycle after hostRe.
- R8: A host read at 0x1000 or above returns RAM byte {current bank, address[OFS_W-1:0]} in the next cycle. It does so only if `sounding` is 0 and engRdEn is low in the same cycle. All other reads return 0xFF.
- R9: An engine read (engRdEn) of engRdAddr returns that RAM byte on engRdData in the next cycle, whatever the host is doing.
- R10: After reset, `sounding`, `disableMask`, `restartStrobe`, `accClear`, all parameter registers, the bank and the selected voice are 0, and hostRdData is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host byte write strobe |
| hostRe | input | 1 | Host byte read strobe |
| hostAddr | input | ADDR_W | Host byte address |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte, valid the cycle after hostRe |
| slotIdx | input | 4 | Current slot of the 12-slot voice period |
| chanPtr | input | 8*16 | Pointer bits 26:11 of each voice, voice 0 lowest |
| engRdEn | input | 1 | Playback engine RAM read request |
| engRdAddr | input | BANK_W+OFS_W | Playback engine RAM address |
| engRdData | output | 8 | Engine read byte, valid the cycle after engRdEn |
| sounding | output | 1 | Global sounding enable |
| disableMask | output | 8 | Per-voice silence mask |
| restartStrobe | output | 8 | One-cycle restart pulse per voice |
| accClear | output | 1 | One-cycle stereo accumulator clear |
| chanParams | output | 8*7*8 | All voice parameter registers |

## Verification
Register writes and their effects (parameters, `sounding`, mask, restart and clear pulses) show up one edge after the write strobe. The bench raises the strobe at a falling edge and samples at the next falling edge, in the same window where the single-cycle pulses are high. Host reads and engine reads return data one edge after the request, and the bench samples them at the falling edge that follows. A commit lands at the rising edge of the slot cycle. The bench then holds the slot at refresh and reads the location back through the engine port, comparing the data with an outcome it works out from the slot number and the sounding state.

// File: rtl/pcmHostPkg.sv
package pcmHostPkg;
  localparam int NUM_CH     = 8;
  localparam int CH_W       = 3;
  localparam int PARAM_REGS = 7;
  localparam int PTR_FIELD  = 16;
  localparam int WIN_LSB    = 12;

  typedef enum logic [1:0] {RD_FF, RD_PTR, RD_RAM} rdSrcE;

  typedef struct packed {
    logic            paramWe;
    logic [CH_W-1:0] paramIdx;
    logic            ctrlWe;
    logic            maskWe;
    logic            waveWe;
    logic            commitEn;
    logic            rdReq;
    logic            rdPtr;
    logic            rdPtrHigh;
    logic [CH_W-1:0] rdPtrChan;
    logic            rdRam;
  } strobeS;
endpackage

// File: rtl/pcmWaveRam.sv
module pcmWaveRam #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wAddr,
  input  logic [7:0]    wData,
  input  logic          re,
  input  logic [AW-1:0] rAddr,
  output logic [7:0]    q
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wAddr] <= wData;
    if (re) q <= mem[rAddr];
  end
endmodule

// File: rtl/pcmHostCtrl.sv
import pcmHostPkg::*;

module pcmHostCtrl #(
  parameter int ADDR_W = 16
) (
  input  logic              hostWe,
  input  logic              hostRe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              sounding,
  input  logic              pendValid,
  input  logic [3:0]        slotIdx,
  input  logic              engRdEn,
  output strobeS            strobes
);
  logic inWindow, lowPage, slotOpen;

  always_comb begin
    inWindow = |hostAddr[ADDR_W-1:WIN_LSB];
    lowPage  = (hostAddr[ADDR_W-1:4] == '0);
    unique case (slotIdx)
      4'd3, 4'd7, 4'd11:                               slotOpen = 1'b1;
      4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9:  slotOpen = !sounding;
      default:                                         slotOpen = 1'b0;
    endcase

    strobes           = '0;
    strobes.paramWe   = hostWe && lowPage && (hostAddr[3:0] < 4'(PARAM_REGS));
    strobes.paramIdx  = hostAddr[CH_W-1:0];
    strobes.ctrlWe    = hostWe && lowPage && (hostAddr[3:0] == 4'd7);
    strobes.maskWe    = hostWe && lowPage && (hostAddr[3:0] == 4'd8);
    strobes.waveWe    = hostWe && inWindow;
    strobes.commitEn  = pendValid && slotOpen;
    strobes.rdReq     = hostRe;
    strobes.rdPtr     = hostRe && (hostAddr[ADDR_W-1:5] == '0) && hostAddr[4];
    strobes.rdPtrHigh = hostAddr[0];
    strobes.rdPtrChan = hostAddr[CH_W:1];
    strobes.rdRam     = hostRe && inWindow && !sounding && !engRdEn;
  end
endmodule

// File: rtl/pcmHostDatapath.sv
import pcmHostPkg::*;

module pcmHostDatapath #(
  parameter int OFS_W  = 8,
  parameter int BANK_W = 4
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  strobeS                               strobes,
  input  logic [OFS_W-1:0]                     hostOfs,
  input  logic [7:0]                           hostWrData,
  input  logic [NUM_CH*PTR_FIELD-1:0]          chanPtr,
  input  logic                                 engRdEn,
  input  logic [BANK_W+OFS_W-1:0]              engRdAddr,
  output logic [7:0]                           engRdData,
  output logic [7:0]                           hostRdData,
  output logic                                 sounding,
  output logic                                 pendValid,
  output logic [NUM_CH-1:0]                    disableMask,
  output logic [NUM_CH-1:0]                    restartStrobe,
  output logic                                 accClear,
  output logic [NUM_CH*PARAM_REGS*8-1:0]       chanParams
);
  localparam int RAM_AW = BANK_W + OFS_W;

  logic [CH_W-1:0]   selChan;
  logic [BANK_W-1:0] bank;
  logic [RAM_AW-1:0] pendAddr;
  logic [7:0]        pendData;
  rdSrcE             rdSrc;
  logic [7:0]        ptrByte, ramQ;
  logic [PTR_FIELD-1:0] ptrWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sounding      <= 1'b0;
      selChan       <= '0;
      bank          <= '0;
      disableMask   <= '0;
      restartStrobe <= '0;
      accClear      <= 1'b0;
    end else begin
      accClear      <= strobes.ctrlWe && !hostWrData[7];
      restartStrobe <= strobes.maskWe ? (hostWrData & ~disableMask) : '0;
      if (strobes.maskWe) disableMask <= hostWrData;
      if (strobes.ctrlWe) begin
        sounding <= hostWrData[7];
        if (hostWrData[6]) selChan <= hostWrData[CH_W-1:0];
        else               bank    <= hostWrData[BANK_W-1:0];
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gVoice
    logic [7:0] regs [PARAM_REGS];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int r = 0; r < PARAM_REGS; r++) regs[r] <= '0;
      end else if (strobes.paramWe && selChan == CH_W'(ch)) begin
        regs[strobes.paramIdx] <= hostWrData;
      end
    end
    for (genvar r = 0; r < PARAM_REGS; r++) begin : gReg
      assign chanParams[(ch*PARAM_REGS+r)*8 +: 8] = regs[r];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendData  <= '0;
    end else if (strobes.waveWe) begin
      pendValid <= 1'b1;
      pendAddr  <= {bank, hostOfs};
      pendData  <= hostWrData;
    end else if (strobes.commitEn) begin
      pendValid <= 1'b0;
    end
  end

  pcmWaveRam #(.AW(RAM_AW)) ram_i (
    .clk   (clk),
    .we    (strobes.commitEn),
    .wAddr (pendAddr),
    .wData (pendData),
    .re    (engRdEn || strobes.rdRam),
    .rAddr (engRdEn ? engRdAddr : {bank, hostOfs}),
    .q     (ramQ)
  );

  assign ptrWord = chanPtr[strobes.rdPtrChan*PTR_FIELD +: PTR_FIELD];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdSrc   <= RD_FF;
      ptrByte <= '0;
    end else if (strobes.rdReq) begin
      ptrByte <= strobes.rdPtrHigh ? ptrWord[15:8] : ptrWord[7:0];
      if (strobes.rdPtr)      rdSrc <= RD_PTR;
      else if (strobes.rdRam) rdSrc <= RD_RAM;
      else                    rdSrc <= RD_FF;
    end
  end

  always_comb begin
    unique case (rdSrc)
      RD_PTR:  hostRdData = ptrByte;
      RD_RAM:  hostRdData = ramQ;
      default: hostRdData = 8'hFF;
    endcase
  end

  assign engRdData = ramQ;
endmodule

// File: rtl/pcm_host_port.sv
import pcmHostPkg::*;

module pcm_host_port #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 8,
  parameter int BANK_W = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                hostWe,
  input  logic                                hostRe,
  input  logic [ADDR_W-1:0]                   hostAddr,
  input  logic [7:0]                          hostWrData,
  output logic [7:0]                          hostRdData,
  input  logic [3:0]                          slotIdx,
  input  logic [NUM_CH*PTR_FIELD-1:0]         chanPtr,
  input  logic                                engRdEn,
  input  logic [BANK_W+OFS_W-1:0]             engRdAddr,
  output logic [7:0]                          engRdData,
  output logic                                sounding,
  output logic [NUM_CH-1:0]                   disableMask,
  output logic [NUM_CH-1:0]                   restartStrobe,
  output logic                                accClear,
  output logic [NUM_CH*PARAM_REGS*8-1:0]      chanParams
);
  strobeS strobes;
  logic   pendValid;

  pcmHostCtrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .hostWe    (hostWe),
    .hostRe    (hostRe),
    .hostAddr  (hostAddr),
    .sounding  (sounding),
    .pendValid (pendValid),
    .slotIdx   (slotIdx),
    .engRdEn   (engRdEn),
    .strobes   (strobes)
  );

  pcmHostDatapath #(.OFS_W(OFS_W), .BANK_W(BANK_W)) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .hostOfs       (hostAddr[OFS_W-1:0]),
    .hostWrData    (hostWrData),
    .chanPtr       (chanPtr),
    .engRdEn       (engRdEn),
    .engRdAddr     (engRdAddr),
    .engRdData     (engRdData),
    .hostRdData    (hostRdData),
    .sounding      (sounding),
    .pendValid     (pendValid),
    .disableMask   (disableMask),
    .restartStrobe (restartStrobe),
    .accClear      (accClear),
    .chanParams    (chanParams)
  );
endmodule

// File: rtl/pcmHostChecker.sv
module pcmHostChecker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWe,
  input logic              hostRe,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [7:0]        hostWrData,
  input logic [3:0]        slotIdx,
  input logic              sounding,
  input logic [7:0]        disableMask,
  input logic [7:0]        restartStrobe,
  input logic              accClear,
  input logic [7:0]        hostRdData,
  input logic              commitEn
);
  a_r3_clear_only_on_stop: assert property (@(posedge clk) disable iff (!rstN)
    accClear |-> $past(hostWe && hostAddr == ADDR_W'(7) && !hostWrData[7]));

  a_r4_restart_after_mask: assert property (@(posedge clk) disable iff (!rstN)
    (|restartStrobe) |-> $past(hostWe && hostAddr == ADDR_W'(8)));

  a_r4_restart_in_mask: assert property (@(posedge clk) disable iff (!rstN)
    (|restartStrobe) |-> ((restartStrobe & ~disableMask) == 8'h00));

  a_r2_sounding_held: assert property (@(posedge clk) disable iff (!rstN)
    !$past(hostWe && hostAddr == ADDR_W'(7)) |-> $stable(sounding));

  a_r6_refresh_never: assert property (@(posedge clk) disable iff (!rstN)
    (slotIdx >= 4'd10 && slotIdx != 4'd11) |-> !commitEn);

  a_r6_sounding_slots: assert property (@(posedge clk) disable iff (!rstN)
    (commitEn && sounding) |-> (slotIdx == 4'd3 || slotIdx == 4'd7 || slotIdx == 4'd11));

  a_r8_blocked_when_sounding: assert property (@(posedge clk) disable iff (!rstN)
    $past(hostRe && sounding && (|hostAddr[ADDR_W-1:12])) |-> hostRdData == 8'hFF);
endmodule

bind pcm_host_port pcmHostChecker #(.ADDR_W(ADDR_W)) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .hostWe        (hostWe),
  .hostRe        (hostRe),
  .hostAddr      (hostAddr),
  .hostWrData    (hostWrData),
  .slotIdx       (slotIdx),
  .sounding      (sounding),
  .disableMask   (disableMask),
  .restartStrobe (restartStrobe),
  .accClear      (accClear),
  .hostRdData    (hostRdData),
  .commitEn      (strobes.commitEn)
);

// File: tb/pcm_host_port_tb_top.sv
module pcm_host_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         hostWe = 1'b0, hostRe = 1'b0, engRdEn = 1'b0;
  logic [15:0]  hostAddr = '0;
  logic [7:0]   hostWrData = '0;
  logic [3:0]   slotIdx = 4'd10;
  logic [127:0] chanPtr;
  logic [11:0]  engRdAddr = '0;
  logic [7:0]   hostRdData, engRdData, disableMask, restartStrobe;
  logic         sounding, accClear;
  logic [447:0] chanParams;

  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_host_port dut_i (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostRe(hostRe), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .slotIdx(slotIdx),
    .chanPtr(chanPtr), .engRdEn(engRdEn), .engRdAddr(engRdAddr), .engRdData(engRdData),
    .sounding(sounding), .disableMask(disableMask), .restartStrobe(restartStrobe),
    .accClear(accClear), .chanParams(chanParams)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); hostWe = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk); hostWe = 1'b0;
  endtask

  task automatic hostRead(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk); hostRe = 1'b1; hostAddr = a;
    @(negedge clk); hostRe = 1'b0; v = hostRdData;
  endtask

  task automatic engRead(input logic [11:0] a, output logic [7:0] v);
    @(negedge clk); engRdEn = 1'b1; engRdAddr = a;
    @(negedge clk); engRdEn = 1'b0; v = engRdData;
  endtask

  task automatic pulseSlot(input logic [3:0] s);
    @(negedge clk); slotIdx = s;
    @(negedge clk); slotIdx = 4'd10;
  endtask

  function automatic logic [7:0] paramVal(input int c, input int r);
    return 8'((c * 16 + r) ^ 8'hA5);
  endfunction

  initial begin
    for (int c = 0; c < 8; c++) chanPtr[c*16 +: 16] = 16'((c * 16'h1357 + 16'h2468) & 16'hFFFF);
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 sounding", 32'(sounding), 0);
    check("R10 mask", 32'(disableMask), 0);
    check("R10 restart", 32'(restartStrobe), 0);
    check("R10 accClear", 32'(accClear), 0);
    check("R10 hostRdData", 32'(hostRdData), 32'hFF);
    check("R10 params zero", 32'(|chanParams), 0);

    // R1 parameter registers, every voice and register
    for (int c = 0; c < 8; c++) begin
      writeReg(16'd7, 8'(8'h40 | c));
      for (int r = 0; r < 7; r++) writeReg(16'(r), paramVal(c, r));
    end
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 7; r++)
        check($sformatf("R1 voice %0d reg %0d", c, r),
              32'(chanParams[(c*7+r)*8 +: 8]), 32'(paramVal(c, r)));

    // R7 pointer reads
    for (int a = 16; a < 32; a++) begin
      logic [15:0] w;
      hostRead(16'(a), v);
      w = chanPtr[((a >> 1) & 7)*16 +: 16];
      check($sformatf("R7 ptr addr %0h", a), 32'(v), 32'((a & 1) ? w[15:8] : w[7:0]));
    end

    // R6 commit gating sweep over slot and sounding state
    for (int snd = 0; snd < 2; snd++) begin
      for (int s = 0; s < 16; s++) begin
        logic [7:0] ofs, val;
        logic committed;
        ofs = 8'(s * 2 + snd);
        val = 8'(8'h40 + s + snd * 16);
        committed = (s == 3 || s == 7 || s == 11) || (snd == 0 && s < 12 && s != 10);
        writeReg(16'd7, 8'h01);
        writeReg(16'h1000 | 16'(ofs), 8'h00);
        pulseSlot(4'd3);
        writeReg(16'd7, 8'(snd << 7 | 1));
        writeReg(16'h1000 | 16'(ofs), val);
        pulseSlot(4'(s));
        engRead({4'd1, ofs}, v);
        check($sformatf("R6 slot %0d sounding %0d", s, snd), 32'(v), 32'(committed ? val : 8'h00));
        pulseSlot(4'd3);
      end
    end
    writeReg(16'd7, 8'h00);

    // R5 bank captured at write time
    writeReg(16'd7, 8'h02); writeReg(16'h1033, 8'h00); pulseSlot(4'd3);
    writeReg(16'd7, 8'h05); writeReg(16'h1033, 8'h00); pulseSlot(4'd3);
    writeReg(16'd7, 8'h02); writeReg(16'h1033, 8'h9C);
    writeReg(16'd7, 8'h05); pulseSlot(4'd3);
    engRead(12'h233, v); check("R5 captured bank target", 32'(v), 32'h9C);
    engRead(12'h533, v); check("R5 new bank untouched", 32'(v), 32'h00);

    // R5 newer write replaces held byte
    writeReg(16'd7, 8'h02);
    writeReg(16'h1044, 8'h00); pulseSlot(4'd3);
    writeReg(16'h1045, 8'h00); pulseSlot(4'd3);
    writeReg(16'h1044, 8'h11); writeReg(16'h1045, 8'h22); pulseSlot(4'd3);
    engRead(12'h245, v); check("R5 newer byte committed", 32'(v), 32'h22);
    engRead(12'h244, v); check("R5 older byte dropped", 32'(v), 32'h00);

    // R2 voice select keeps bank; sounding bit
    writeReg(16'd7, 8'h03); writeReg(16'd7, 8'h46);
    writeReg(16'h1050, 8'h77); pulseSlot(4'd3);
    engRead(12'h350, v); check("R2 bank kept on voice select", 32'(v), 32'h77);
    check("R2 sounding off", 32'(sounding), 0);

    // R8 host RAM reads
    hostRead(16'h1050, v); check("R8 read when silent", 32'(v), 32'h77);
    writeReg(16'd7, 8'h83);
    check("R2 sounding on", 32'(sounding), 1);
    hostRead(16'h1050, v); check("R8 blocked when sounding", 32'(v), 32'hFF);
    writeReg(16'd7, 8'h03);
    hostRead(16'h0020, v); check("R8 unmapped read", 32'(v), 32'hFF);
    @(negedge clk); hostRe = 1'b1; hostAddr = 16'h1050; engRdEn = 1'b1; engRdAddr = 12'h233;
    @(negedge clk); hostRe = 1'b0; engRdEn = 1'b0;
    check("R8 engine collision", 32'(hostRdData), 32'hFF);
    check("R9 engine wins port", 32'(engRdData), 32'h9C);

    // R3 accumulator clear
    writeReg(16'd7, 8'h00); check("R3 clear on stop", 32'(accClear), 1);
    writeReg(16'd7, 8'h80); check("R3 no clear when sounding", 32'(accClear), 0);
    writeReg(16'd7, 8'h41); check("R3 clear on voice select stop", 32'(accClear), 1);
    writeReg(16'd8, 8'h00); check("R3 no clear on mask write", 32'(accClear), 0);

    // R4 mask and restart pulses
    writeReg(16'd8, 8'h0F);
    check("R4 restart 0F", 32'(restartStrobe), 32'h0F);
    check("R4 mask 0F", 32'(disableMask), 32'h0F);
    writeReg(16'd8, 8'h3C);
    check("R4 restart rising only", 32'(restartStrobe), 32'h30);
    check("R4 mask 3C", 32'(disableMask), 32'h3C);
    writeReg(16'd8, 8'h00);
    check("R4 no restart on clear", 32'(restartStrobe), 0);
    @(negedge clk);
    check("R4 pulse one cycle", 32'(restartStrobe), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule